// File: doc/BRIEF.md
# Load-Locked Reservation Monitor

This block holds the reservation created when a processor executes a load-locked instruction, and it decides whether the matching store-conditional may complete. The processor loads the reservation with an explicit command. The block then watches every bus transaction through a snoop port. A bus write to the reserved cache block cancels the reservation. Any bus transaction that touches the reserved block, read or write, gets a shared response from this node. That response keeps later writes to the block on the bus even after the block has been evicted from the local cache.

All address comparisons are made on whole cache blocks: the low offset bits are ignored. A store-conditional query returns its verdict one cycle later. Every store-conditional consumes the reservation, whether it passes or fails.

Top module: `llrm_monitor`

## Requirements
- R1: After a synchronous active-low reset, the reservation is clear and `snp_shared`, `sc_done` and `sc_pass` are all low, so a store-conditional issued straight after reset fails.
- R2: A cycle with `ll_valid` high stores the block address of `ll_addr` and sets the reservation. A later load-locked replaces the stored block, and only this command changes the stored address.
- R3: Every comparison uses address bits `[ADDR_W-1:BLK_OFF]` only. Addresses that differ only in the low `BLK_OFF` bits (6 by default) are treated as the same block.
- R4: `snp_shared` is high in the cycle after a `snp_valid` cycle exactly when the snooped block equals the reserved block and the reservation was set in the snoop cycle. This applies to reads (`snp_write`=0) and to writes (`snp_write`=1). Otherwise `snp_shared` is low.
- R5: A snooped write to the reserved block clears the reservation. A snooped read to it, or a write to any other block, leaves the reservation intact.
- R6: `sc_pass` is high in the cycle after `sc_valid` exactly when the reservation is set and `sc_addr` names the reserved block, subject to R8.
- R7: Any store-conditional, passing or failing, clears the reservation afterwards.
- R8: When a snooped write to the reserved block arrives in the same cycle as a store-conditional, the store-conditional fails.
- R9: When `ll_valid` coincides with a clearing event (a matching snoop write or a store-conditional), the load-locked wins: the reservation ends up set on the new block.
- R10: `sc_done` pulses high for exactly the one cycle after each `sc_valid` cycle and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ll_valid | input | 1 | Processor load-locked command |
| ll_addr | input | ADDR_W | Address of the load-locked |
| sc_valid | input | 1 | Store-conditional query |
| sc_addr | input | ADDR_W | Address of the store-conditional |
| sc_done | output | 1 | Verdict strobe, one cycle after the query |
| sc_pass | output | 1 | Store-conditional may complete (valid with `sc_done`) |
| snp_valid | input | 1 | Bus transaction present on the snoop port |
| snp_write | input | 1 | 1 = bus write, 0 = bus read |
| snp_addr | input | ADDR_W | Bus transaction address |
| snp_shared | output | 1 | Shared response for the previous snoop |

## Verification
The hardest situations to reach are the same-cycle collisions. One is a matching bus write landing in the very cycle of a store-conditional. Another is a new load-locked arriving together with a clearing write while the old reservation is still live. In each collision, two clearing and setting causes meet on one register. The stimulus reaches them by first arming the reservation with a load-locked. It then drives the colliding inputs together in one cycle. Next, it follows with a plain store-conditional or snoop, which shows at the ports which cause won. Offset-only address differences are mixed into the snoops and queries to prove that the comparison is made at block granularity.

// File: rtl/llrm_pkg.sv
// Shared types for the load-locked reservation monitor.
// Assumes: nothing beyond SystemVerilog 2017.
package llrm_pkg;

    // Next-cycle action applied to the reservation register.
    typedef enum logic [1:0] {
        EVT_HOLD  = 2'd0,
        EVT_LOAD  = 2'd1,
        EVT_CLEAR = 2'd2
    } resv_evt_e;

endpackage

// File: rtl/llrm_blk_match.sv
// Cache-block address comparator.
// Does: flags equality of two addresses, ignoring the low BLK_OFF offset bits.
// Assumes: BLK_OFF < ADDR_W; purely combinational.
module llrm_blk_match #(
    parameter int ADDR_W  = 32,
    parameter int BLK_OFF = 6
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_blk
);
    localparam logic [ADDR_W-1:0] BLK_MASK = {{(ADDR_W-BLK_OFF){1'b1}}, {BLK_OFF{1'b0}}};

    // Compare only the block-number bits.
    always_comb begin
        same_blk = (((addr_a ^ addr_b) & BLK_MASK) == '0);
    end
endmodule

// File: rtl/llrm_resv_reg.sv
// Reservation register: the stored block address and the lock bit.
// Does: loads on EVT_LOAD, drops the lock on EVT_CLEAR, holds otherwise.
// Assumes: the caller has already resolved priority into a single event.
module llrm_resv_reg
    import llrm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BLK_OFF = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  resv_evt_e         evt,
    input  logic [ADDR_W-1:0] load_addr,
    output logic              lock_q,
    output logic [ADDR_W-1:0] addr_q
);
    localparam logic [ADDR_W-1:0] BLK_MASK = {{(ADDR_W-BLK_OFF){1'b1}}, {BLK_OFF{1'b0}}};

    // Lock bit update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else begin
            case (evt)
                EVT_LOAD:  lock_q <= 1'b1;
                EVT_CLEAR: lock_q <= 1'b0;
                default:   lock_q <= lock_q;
            endcase
        end
    end

    // Stored block address; offset bits kept at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (evt == EVT_LOAD) begin
            addr_q <= load_addr & BLK_MASK;
        end
    end

    assert_load_sets_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EVT_LOAD) |=> lock_q);

    assert_addr_only_by_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != EVT_LOAD) |=> $stable(addr_q));

    assert_clear_drops_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EVT_CLEAR) |=> !lock_q);
endmodule

// File: rtl/llrm_resp.sv
// Response registers for the snoop and store-conditional ports.
// Does: registers the shared response and the store-conditional verdict.
// Assumes: decisions arrive already qualified by the lock bit.
module llrm_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic shared_d,
    input  logic done_d,
    input  logic pass_d,
    output logic snp_shared,
    output logic sc_done,
    output logic sc_pass
);
    // One-cycle registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snp_shared <= 1'b0;
            sc_done    <= 1'b0;
            sc_pass    <= 1'b0;
        end else begin
            snp_shared <= shared_d;
            sc_done    <= done_d;
            sc_pass    <= pass_d;
        end
    end
endmodule

// File: rtl/llrm_monitor.sv
// Load-locked reservation monitor (top).
// Does: holds one reservation, snoops bus traffic, gives the shared response
//       and judges store-conditionals.
// Assumes: at most one bus transaction and one processor query per cycle.
//          Priority per cycle: load-locked > clearing (snoop write hit or SC).
module llrm_monitor
    import llrm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BLK_OFF = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    output logic              sc_done,
    output logic              sc_pass,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared
);
    localparam int N_CMP = 2;   // port 0: snoop, port 1: store-conditional

    logic              lock_q;
    logic [ADDR_W-1:0] resv_addr;
    logic [N_CMP-1:0]  hit;
    logic [ADDR_W-1:0] cmp_addr [N_CMP];
    logic              wr_kill;
    logic              shared_d;
    logic              pass_d;
    resv_evt_e         evt;

    // Route each requester's address to its comparator.
    always_comb begin
        cmp_addr[0] = snp_addr;
        cmp_addr[1] = sc_addr;
    end

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        llrm_blk_match #(.ADDR_W(ADDR_W), .BLK_OFF(BLK_OFF)) u_match (
            .addr_a   (cmp_addr[g]),
            .addr_b   (resv_addr),
            .same_blk (hit[g])
        );
    end

    // Decide this cycle's reservation event and port responses.
    always_comb begin
        wr_kill  = snp_valid && snp_write && hit[0] && lock_q;
        shared_d = snp_valid && hit[0] && lock_q;
        pass_d   = sc_valid && hit[1] && lock_q && !wr_kill;
        if (ll_valid)
            evt = EVT_LOAD;
        else if (wr_kill || sc_valid)
            evt = EVT_CLEAR;
        else
            evt = EVT_HOLD;
    end

    llrm_resv_reg #(.ADDR_W(ADDR_W), .BLK_OFF(BLK_OFF)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .load_addr (ll_addr),
        .lock_q    (lock_q),
        .addr_q    (resv_addr)
    );

    llrm_resp u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .shared_d   (shared_d),
        .done_d     (sc_valid),
        .pass_d     (pass_d),
        .snp_shared (snp_shared),
        .sc_done    (sc_done),
        .sc_pass    (sc_pass)
    );

    assert_shared_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !lock_q) |=> !snp_shared);

    assert_no_shared_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> !snp_shared);

    assert_done_after_sc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |=> sc_done);

    assert_no_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_valid |=> !sc_done);

    assert_wr_hit_fails_sc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && snp_valid && snp_write && hit[0] && lock_q) |=> !sc_pass);

    assert_wr_hit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_write && hit[0] && lock_q && !ll_valid) |=> !lock_q);

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_valid && (sc_valid || (snp_valid && snp_write))) |=> lock_q);
endmodule

// File: tb/llrm_monitor_tb.sv
// Scoreboard bench for llrm_monitor.
module llrm_monitor_tb_top;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ll_valid = 1'b0;
    logic [ADDR_W-1:0] ll_addr = '0;
    logic              sc_valid = 1'b0;
    logic [ADDR_W-1:0] sc_addr = '0;
    logic              sc_done;
    logic              sc_pass;
    logic              snp_valid = 1'b0;
    logic              snp_write = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_shared;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [2:0] exp_q [$];   // {shared, done, pass}
    string      tag_q [$];

    always #2 clk = ~clk;    // 250 MHz

    llrm_monitor #(.ADDR_W(ADDR_W), .BLK_OFF(6)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr),
        .sc_done(sc_done), .sc_pass(sc_pass),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .snp_shared(snp_shared)
    );

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected outputs.
    task automatic step(input bit ll, input logic [31:0] la,
                        input bit sc, input logic [31:0] sa,
                        input bit sv, input bit sw, input logic [31:0] pa,
                        input bit e_sh, input bit e_pass, input string tag);
        @(negedge clk);
        ll_valid = ll; ll_addr = la;
        sc_valid = sc; sc_addr = sa;
        snp_valid = sv; snp_write = sw; snp_addr = pa;
        exp_q.push_back({e_sh, sc, e_pass});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare outputs just after each edge against the oldest item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exp_q.size() > 0) begin
                logic [2:0] e;
                logic [2:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {snp_shared, sc_done, sc_pass};
                n_cmp++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: {shared,done,pass} actual=%b expected=%b", t, a, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    localparam logic [31:0] A  = 32'h1000_0040;
    localparam logic [31:0] B  = 32'h3000_0100;
    localparam logic [31:0] C  = 32'h5000_0A00;
    localparam logic [31:0] D  = 32'h7000_0000;

    initial begin
        // R1: outputs low during and straight out of reset
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if ({snp_shared, sc_done, sc_pass} !== 3'b000) begin
            n_bad++;
            $display("FAIL R1 reset: actual=%b expected=000", {snp_shared, sc_done, sc_pass});
        end
        @(negedge clk);
        rst_n = 1'b1;
        //    ll    la  sc    sa            sv    sw    pa            sh    pass
        step(1'b0, '0, 1'b1, A,            1'b1, 1'b0, A,            1'b0, 1'b0, "R1 sc/snoop after reset");
        step(1'b1, A,  1'b0, '0,           1'b0, 1'b0, '0,           1'b0, 1'b0, "R2 load-locked A");
        step(1'b0, '0, 1'b0, '0,           1'b1, 1'b0, A + 32'h4,    1'b1, 1'b0, "R3 R4 snoop read same block");
        step(1'b0, '0, 1'b0, '0,           1'b1, 1'b0, D,            1'b0, 1'b0, "R4 snoop read other block");
        step(1'b0, '0, 1'b0, '0,           1'b1, 1'b1, D,            1'b0, 1'b0, "R5 write other block keeps lock");
        step(1'b0, '0, 1'b1, A + 32'h30,   1'b0, 1'b0, '0,           1'b0, 1'b1, "R6 R3 sc pass offset differs");
        step(1'b0, '0, 1'b1, A,            1'b0, 1'b0, '0,           1'b0, 1'b0, "R7 sc after sc fails");
        step(1'b0, '0, 1'b0, '0,           1'b1, 1'b0, A,            1'b0, 1'b0, "R4 no shared without lock");
        // matching write clears
        step(1'b1, A,  1'b0, '0,           1'b0, 1'b0, '0,           1'b0, 1'b0, "R2 reload A");
        step(1'b0, '0, 1'b0, '0,           1'b1, 1'b1, A + 32'h3F,   1'b1, 1'b0, "R4 R5 snoop write hit shared");
        step(1'b0, '0, 1'b1, A,            1'b0, 1'b0, '0,           1'b0, 1'b0, "R5 sc fails after write hit");
        // read does not clear, wrong-block sc fails and still clears
        step(1'b1, B,  1'b0, '0,           1'b0, 1'b0, '0,           1'b0, 1'b0, "R2 load-locked B");
        step(1'b0, '0, 1'b0, '0,           1'b1, 1'b0, B,            1'b1, 1'b0, "R5 read hit shared");
        step(1'b0, '0, 1'b1, B + 32'h40,   1'b0, 1'b0, '0,           1'b0, 1'b0, "R6 sc next block fails");
        step(1'b0, '0, 1'b1, B,            1'b0, 1'b0, '0,           1'b0, 1'b0, "R7 failed sc cleared lock");
        // same-cycle write hit and sc
        step(1'b1, B,  1'b0, '0,           1'b0, 1'b0, '0,           1'b0, 1'b0, "R2 load-locked B again");
        step(1'b0, '0, 1'b1, B,            1'b1, 1'b1, B + 32'h8,    1'b1, 1'b0, "R8 write hit with sc fails");
        step(1'b0, '0, 1'b1, B,            1'b0, 1'b0, '0,           1'b0, 1'b0, "R8 lock gone afterwards");
        // load-locked beats a coincident clear
        step(1'b1, B,  1'b0, '0,           1'b0, 1'b0, '0,           1'b0, 1'b0, "R2 arm B");
        step(1'b1, B,  1'b0, '0,           1'b1, 1'b1, B,            1'b1, 1'b0, "R9 ll with write hit");
        step(1'b0, '0, 1'b1, B,            1'b0, 1'b0, '0,           1'b0, 1'b1, "R9 lock survives");
        step(1'b1, C,  1'b1, B,            1'b0, 1'b0, '0,           1'b0, 1'b0, "R9 ll with sc, no lock");
        // replaced address
        step(1'b0, '0, 1'b0, '0,           1'b1, 1'b1, B,            1'b0, 1'b0, "R2 old block not watched");
        step(1'b0, '0, 1'b1, C + 32'h10,   1'b0, 1'b0, '0,           1'b0, 1'b1, "R2 R9 sc on new block passes");
        idle("R10 no done when idle");
        idle("R10 idle");
        wait (exp_q.size() == 0);
        @(negedge clk);
        report();
    end
endmodule